// File: doc/BRIEF.md
# Tiled Framebuffer Scanline Address Generator

This block produces the byte address of every pixel of a 32-bit-per-pixel framebuffer held in a three-level tiled layout, visiting the pixels in display order: left to right along a line, then the next line down. A display engine that reads one scanline at a time uses it to turn (x, y) positions into memory addresses without doing any multiplication per pixel.

The layout nests three levels. A 64-byte micro-tile holds 4x4 pixels. A 1 KB subtile holds 4x4 micro-tiles. A 4 KB tile holds 2x2 subtiles. The order of the subtiles in memory depends on whether the tile row is even or odd. Tiles are placed left to right in even tile rows and right to left in odd ones. A start pulse loads the base address and the image size. The block then emits one address per handshake on a valid/ready stream, with the pixel coordinates beside each address, and pulses done when the last pixel has been taken.

Top module: `tfmt_addr_gen`

## Requirements
- R1: After reset, valid_o and done_o are low.
- R2: After a start accepted while idle with nonzero width and height, valid_o rises on the next cycle with x_o=0 and y_o=0. Each handshake advances x_o by one. After x_o=width-1 it wraps to 0 and y_o advances by one, until (width-1, height-1).
- R3: Address bits [5:2] minus the base give the pixel position inside its micro-tile as (y mod 4)*4+(x mod 4). Bits [1:0] add nothing to the base.
- R4: Address bits [9:6] give the micro-tile position inside its subtile as ((y mod 16) div 4)*4+((x mod 16) div 4).
- R5: Address bits [11:10] give the subtile slot. A subtile is "bottom" when (y mod 32)<16 and "left" when (x mod 32)<16. In even tile rows the slots are bottom-left=0, top-left=1, top-right=2, bottom-right=3. In odd tile rows they are top-right=0, bottom-right=1, bottom-left=2, top-left=3.
- R6: Address bits above 11 (relative to a base aligned to 4096) give the tile index ty*T+slot. Here T=(width+31)>>5, ty=y div 32 and tx=x div 32. The slot is tx in even tile rows and T-1-tx in odd tile rows. Pixels in a partial right-edge tile use the same full-tile addressing.
- R7: While valid_o is high and ready_i is low, valid_o, addr_o, x_o and y_o stay unchanged on the next cycle.
- R8: done_o is high for exactly one cycle, the cycle after the final handshake, and valid_o is low in that cycle.
- R9: A start pulse while a scan is in progress is ignored. The running scan continues with its original base and size.
- R10: A start with width or height zero produces no beats, and done_o pulses on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted while idle |
| base_i | input | AW | Framebuffer base byte address |
| width_i | input | DW | Image width in pixels |
| height_i | input | DW | Image height in pixels |
| ready_i | input | 1 | Consumer ready for an address |
| valid_o | output | 1 | Address beat valid |
| addr_o | output | AW | Byte address of the pixel |
| x_o | output | DW | Pixel column of the beat |
| y_o | output | DW | Pixel row of the beat |
| done_o | output | 1 | One-cycle pulse after the final beat |

## Verification
The hardest behaviour to reach from the ports is the odd-row mirroring in a partial right-edge tile. Here T-1-tx and the odd subtile table act together on columns beyond the image width. The stimulus therefore uses widths of 40 and 33, which are not multiples of 32, and heights that cross two to three tile rows. Every beat is decomposed into its four address fields and compared against arithmetic in the bench. Irregular ready patterns exercise the stall hold at tile and line boundaries. A start pulse is injected mid-scan with different dimensions.

// File: rtl/tfmt_pkg.sv
// Shared helpers for the tiled-framebuffer address generator.
// Assumes 32-bit pixels: micro-tile 4x4, subtile 16x16, tile 32x32 pixels.
package tfmt_pkg;

    // Slot of a subtile within its tile, chosen by tile-row parity.
    // top: subtile half with the larger row index; right: larger column half.
    function automatic logic [1:0] subtile_slot(input logic odd_row,
                                                input logic top,
                                                input logic right);
        logic [1:0] s;
        if (!odd_row) begin
            case ({top, right})
                2'b00:   s = 2'd0;
                2'b10:   s = 2'd1;
                2'b11:   s = 2'd2;
                default: s = 2'd3;
            endcase
        end else begin
            case ({top, right})
                2'b11:   s = 2'd0;
                2'b01:   s = 2'd1;
                2'b00:   s = 2'd2;
                default: s = 2'd3;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/tfmt_scan_ctr.sv
// Scan sequencer: latches the configuration on start and walks x then y
// on each accepted beat. Keeps a running tile-row base (ty * tiles per row)
// so the address path needs no multiplier. Assumes start is a pulse.
module tfmt_scan_ctr #(
    parameter int AW = 32,
    parameter int DW = 12,
    parameter int TW = DW - 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [AW-1:0]   base_i,
    input  logic [DW-1:0]   width_i,
    input  logic [DW-1:0]   height_i,
    input  logic            ready_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [DW-1:0]   x_o,
    output logic [DW-1:0]   y_o,
    output logic [AW-1:0]   base_o,
    output logic [TW-1:0]   tpr_o,
    output logic [2*TW-1:0] rowbase_o
);

    logic [DW:0]   w_round;
    logic [TW-1:0] tpr_next;
    logic [DW-1:0] w_q, h_q;
    logic          last_x, last_y;

    // Tiles per row: width rounded up to a multiple of 32, over 32.
    assign w_round  = {1'b0, width_i} + (DW+1)'(31);
    assign tpr_next = w_round[DW:5];
    assign last_x   = (x_o == w_q - DW'(1));
    assign last_y   = (y_o == h_q - DW'(1));

    // Configuration capture, raster stepping and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o    <= 1'b0;
            done_o    <= 1'b0;
            x_o       <= '0;
            y_o       <= '0;
            base_o    <= '0;
            tpr_o     <= '0;
            rowbase_o <= '0;
            w_q       <= '0;
            h_q       <= '0;
        end else begin
            done_o <= 1'b0;
            if (!busy_o) begin
                if (start_i) begin
                    base_o    <= base_i;
                    w_q       <= width_i;
                    h_q       <= height_i;
                    tpr_o     <= tpr_next;
                    x_o       <= '0;
                    y_o       <= '0;
                    rowbase_o <= '0;
                    if (width_i != '0 && height_i != '0)
                        busy_o <= 1'b1;
                    else
                        done_o <= 1'b1;
                end
            end else if (ready_i) begin
                if (last_x) begin
                    x_o <= '0;
                    if (last_y) begin
                        busy_o <= 1'b0;
                        done_o <= 1'b1;
                    end else begin
                        y_o <= y_o + DW'(1);
                        if (y_o[4:0] == 5'd31)
                            rowbase_o <= rowbase_o + (2*TW)'(tpr_o);
                    end
                end else begin
                    x_o <= x_o + DW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/tfmt_addr_map.sv
// Combinational map from (x, y) to byte address in the tiled layout.
// Assumes 4-byte pixels and that rowbase already equals ty * tiles-per-row.
module tfmt_addr_map #(
    parameter int AW = 32,
    parameter int DW = 12,
    parameter int TW = DW - 4
) (
    input  logic [DW-1:0]   x_i,
    input  logic [DW-1:0]   y_i,
    input  logic [AW-1:0]   base_i,
    input  logic [TW-1:0]   tpr_i,
    input  logic [2*TW-1:0] rowbase_i,
    output logic [AW-1:0]   addr_o
);
    import tfmt_pkg::*;

    localparam int OW = 2*TW + 12;

    logic [TW-1:0]   tx;
    logic [TW-1:0]   slot;
    logic [2*TW-1:0] tile_idx;
    logic [1:0]      sub;
    logic            odd_row;
    logic [OW-1:0]   offset;

    // Tile slot (mirrored in odd rows), subtile slot and packed offset.
    always_comb begin
        odd_row  = y_i[5];
        tx       = TW'(x_i[DW-1:5]);
        slot     = odd_row ? (tpr_i - TW'(1) - tx) : tx;
        tile_idx = rowbase_i + (2*TW)'(slot);
        sub      = subtile_slot(odd_row, y_i[4], x_i[4]);
        offset   = {tile_idx, sub, y_i[3:2], x_i[3:2], y_i[1:0], x_i[1:0], 2'b00};
        addr_o   = base_i + AW'(offset);
    end

endmodule

// File: rtl/tfmt_addr_gen.sv
// Top: scanline-order address stream over a tiled 32-bit framebuffer.
// valid/ready output; done pulses the cycle after the final beat.
// Assumes start is ignored while a scan is running.
module tfmt_addr_gen #(
    parameter int AW = 32,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] base_i,
    input  logic [DW-1:0] width_i,
    input  logic [DW-1:0] height_i,
    input  logic          ready_i,
    output logic          valid_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] x_o,
    output logic [DW-1:0] y_o,
    output logic          done_o
);

    localparam int TW = DW - 4;

    logic [AW-1:0]   base_q;
    logic [TW-1:0]   tpr_q;
    logic [2*TW-1:0] rowbase_q;

    tfmt_scan_ctr #(.AW(AW), .DW(DW), .TW(TW)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .base_i    (base_i),
        .width_i   (width_i),
        .height_i  (height_i),
        .ready_i   (ready_i),
        .busy_o    (valid_o),
        .done_o    (done_o),
        .x_o       (x_o),
        .y_o       (y_o),
        .base_o    (base_q),
        .tpr_o     (tpr_q),
        .rowbase_o (rowbase_q)
    );

    tfmt_addr_map #(.AW(AW), .DW(DW), .TW(TW)) u_map (
        .x_i       (x_o),
        .y_i       (y_o),
        .base_i    (base_q),
        .tpr_i     (tpr_q),
        .rowbase_i (rowbase_q),
        .addr_o    (addr_o)
    );

endmodule

// File: rtl/tfmt_addr_gen_chk.sv
// Protocol checker for tfmt_addr_gen, attached by bind below.
module tfmt_addr_gen_chk #(
    parameter int AW = 32,
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          valid_o,
    input logic          ready_i,
    input logic [AW-1:0] addr_o,
    input logic [DW-1:0] x_o,
    input logic [DW-1:0] y_o,
    input logic          done_o
);

    // R7: a stalled beat is held unchanged.
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(x_o) && $stable(y_o)));

    // R8: done lasts one cycle.
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: no beat is offered while done is high.
    a_r8_done_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !valid_o);

    // R2: after a handshake the column steps by one or wraps to zero.
    a_r2_x_step: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i) |=> (!valid_o || x_o == $past(x_o) + DW'(1) || x_o == '0));

    // R2: the row changes only when the column wraps to zero.
    a_r2_y_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && $past(valid_o)) |=> (!valid_o || $stable(y_o) || x_o == '0));

endmodule

bind tfmt_addr_gen tfmt_addr_gen_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_o (valid_o),
    .ready_i (ready_i),
    .addr_o  (addr_o),
    .x_o     (x_o),
    .y_o     (y_o),
    .done_o  (done_o)
);

// File: tb/sim_tfmt_addr_gen.sv
module sim_tfmt_addr_gen;
    localparam int AW = 32;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] base_i = '0;
    logic [DW-1:0] width_i = '0;
    logic [DW-1:0] height_i = '0;
    logic          ready_i = 1'b0;
    logic          valid_o, done_o;
    logic [AW-1:0] addr_o;
    logic [DW-1:0] x_o, y_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;
    int lfsr = 32'h1ACE;

    tfmt_addr_gen #(.AW(AW), .DW(DW)) u0 (.*);

    always #4 clk = ~clk;

    always @(posedge clk) cycles <= cycles + 1;

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait (cycles >= 190000);
        if (!finished) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected byte offset from a 4096-aligned base, built from the hierarchy.
    function automatic longint exp_off(int x, int y, int w);
        int tpr, ty, tx, slot, ss;
        bit top, right, odd;
        tpr = (w + 31) / 32;
        ty = y / 32;
        tx = x / 32;
        odd = (ty % 2) == 1;
        slot = odd ? (tpr - 1 - tx) : tx;
        top = (y % 32) >= 16;
        right = (x % 32) >= 16;
        if (!odd) ss = (!top && !right) ? 0 : (top && !right) ? 1 : (top && right) ? 2 : 3;
        else      ss = (top && right) ? 0 : (!top && right) ? 1 : (!top && !right) ? 2 : 3;
        return longint'(4096) * (ty * tpr + slot) + 1024 * ss
             + 64 * (((y % 16) / 4) * 4 + (x % 16) / 4) + 4 * ((y % 4) * 4 + x % 4);
    endfunction

    function automatic bit next_ready(int mode);
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
        if (mode == 0) return 1'b1;
        if (mode == 1) return lfsr[0] | lfsr[1];
        return lfsr[2];
    endfunction

    task automatic run_scan(input int base, input int w, input int h, input int mode,
                            input bit poke);
        int ex, ey, beats, limit;
        bit last_taken, hold_prev;
        logic [AW-1:0] pa;
        logic [DW-1:0] px, py;
        longint off;
        @(negedge clk);
        base_i = base; width_i = DW'(w); height_i = DW'(h); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 first valid", valid_o, 1);
        ex = 0; ey = 0; beats = 0; last_taken = 0; hold_prev = 0;
        limit = w * h * 8 + 100;
        for (int c = 0; c < limit; c++) begin
            ready_i = next_ready(mode);
            if (poke && beats == 50) begin
                start_i = 1'b1; base_i = 32'h00F0_0000; width_i = 12'd7; height_i = 12'd3;
            end else begin
                start_i = 1'b0;
            end
            #1;
            if (last_taken) begin
                chk("R8 done after last beat", done_o, 1);
                chk("R8 valid low with done", valid_o, 0);
                break;
            end
            chk("R8 no early done", done_o, 0);
            if (hold_prev) begin
                chk("R7 hold valid", valid_o, 1);
                chk("R7 hold addr", addr_o, pa);
                chk("R7 hold x", x_o, px);
                chk("R7 hold y", y_o, py);
            end
            if (valid_o) begin
                chk(poke ? "R9 x continues" : "R2 x", x_o, ex);
                chk(poke ? "R9 y continues" : "R2 y", y_o, ey);
                off = exp_off(ex, ey, w);
                chk("R3 pixel field", addr_o[5:0], off & 63);
                chk("R4 micro-tile field", addr_o[9:6], (off >> 6) & 15);
                chk("R5 subtile slot", addr_o[11:10], (off >> 10) & 3);
                chk("R6 tile index", longint'(addr_o - AW'(base)) >> 12, off >> 12);
                hold_prev = !ready_i;
                pa = addr_o; px = x_o; py = y_o;
                if (ready_i) begin
                    beats++;
                    if (ex == w - 1) begin
                        ex = 0;
                        if (ey == h - 1) last_taken = 1; else ey++;
                    end else ex++;
                end
            end else begin
                chk("R2 valid during scan", valid_o, 1);
                hold_prev = 0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        chk("R2 beat count", beats, w * h);
        @(negedge clk);
        chk("R8 done one cycle", done_o, 0);
        ready_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 valid after reset", valid_o, 0);
        chk("R1 done after reset", done_o, 0);
        rst_n = 1'b1;
        // Widths that are and are not multiples of 32, several ready patterns.
        run_scan(32'h0010_0000, 64, 64, 0, 0);
        run_scan(32'h0020_0000, 40, 40, 1, 0);
        run_scan(32'h0030_0000, 33, 70, 2, 0);
        run_scan(32'h0040_0000, 96, 33, 1, 1);   // R9 mid-scan start
        run_scan(32'h0050_0000, 1, 5, 0, 0);
        // R10: zero height and zero width.
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            width_i = k ? 12'd0 : 12'd8; height_i = k ? 12'd4 : 12'd0;
            start_i = 1'b1; ready_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            #1;
            chk("R10 done on empty", done_o, 1);
            chk("R10 no beat on empty", valid_o, 0);
            @(negedge clk);
            chk("R10 idle after empty", valid_o, 0);
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule